// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block takes a reference frequency, a flag telling whether that reference comes from a crystal or from the internal RC oscillator, and a requested output frequency. It then works out the PLL input divider, feedback multiplier and output divider code that bring the PLL output closest to the request. First it picks the output divider code from the range the request falls in, and scales the request up to a VCO target. Then it walks the input divider values in the outer loop and the feedback multiplier values in the inner loop. It measures the absolute error of every candidate whose reference-after-divider and VCO frequencies both fall inside their windows.

The search runs in two passes. The first pass records only the smallest error, and it finishes at once if a candidate hits the target exactly. Otherwise the second pass repeats the same walk and takes the first candidate whose error equals that minimum. If the request is out of range, or no candidate is valid, a fixed default setting near 72 MHz is used instead, and the fallback flag is raised. The chosen setting is returned as a packed control word, together with the frequency it produces. The engine uses a single restoring divider that yields one quotient bit per cycle, both for reference/NR and for the final frequency.

Top module: `pll_param_search`

## Requirements
- R1: The output divider code is 0 for 100 MHz < f <= 200 MHz (target = f), 1 for 50 MHz <= f <= 100 MHz (target = 2f), and 3 for 25 MHz <= f < 50 MHz (target = 4f). The code sits in control word bits [15:14] and is never 2.
- R2: A request below 25 MHz or above 200 MHz skips the search and returns the default setting. For a crystal source the default is code 1, NR 2, NF 24. For an RC source it is code 1, NR 4, NF 26. In both cases fallback_o is 1.
- R3: NR is tried from 2 (crystal, src_i = 0) or from 4 (RC, src_i = 1) up to 33. NF is tried upward from 2 to at most 513.
- R4: A candidate is valid only if 1.6 MHz < ref/NR < 15 MHz and 100 MHz <= (ref/NR)*NF <= 200 MHz, where ref/NR is truncated.
- R5: The chosen candidate has the smallest |(ref/NR)*NF - target| over all valid candidates. On a tie, the first one in scan order (NR outer, NF inner) wins, and fallback_o is 0.
- R6: Control word layout: bit 19 = source flag, bits [15:14] = code, bits [13:9] = NR-2, bits [8:0] = NF-2. All other bits are 0.
- R7: freq_hz_o = floor(ref / ((code+1)*NR)) * NF, truncated to 32 bits, for both searched and default settings.
- R8: When the range is valid but no candidate meets R4, the R2 default for the source is returned with fallback_o = 1.
- R9: busy_o is high from the cycle after an accepted start until the result is returned. A start seen while busy is ignored.
- R10: After reset busy_o, done_o, fallback_o, the word and the frequency are 0. done_o is high for exactly one cycle per search, with the outputs already valid.
- R11: The divider returns the exact truncated quotient (quotient*divisor + remainder = dividend).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| src_i | input | 1 | Reference source: 0 crystal, 1 internal RC |
| ref_hz_i | input | 32 | Reference frequency in Hz |
| req_hz_i | input | 32 | Requested output frequency in Hz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| fallback_o | output | 1 | Default setting was used |
| ctrl_word_o | output | 20 | Packed PLL control word |
| freq_hz_o | output | 32 | Achieved output frequency in Hz |

## Verification
The bench drives requests sitting exactly on 25, 50, 100 and 200 MHz and one hertz either side of them. A design with an off-by-one range compare would pick the wrong code or a needless fallback. An RC request whose exact solution needs NR = 3 exposes a scan that starts at 2 for both sources. A reference too low for any NR to meet the window forces the no-candidate fallback; a design that trusts a stale best would return garbage there. Random requests checked against an independent exhaustive search catch tie-break and window errors. A start pulse issued mid-search must leave the first result intact.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
  localparam int WORD_W  = 20;
  localparam int SRC_BIT = 19;
  localparam int CODE_LSB = 14;
  localparam int NRF_LSB = 9;
  localparam int NRF_W   = 5;
  localparam int NFF_W   = 9;

  typedef enum logic [2:0] {
    S_IDLE, S_NR_CHK, S_NR_WAIT, S_SCAN, S_FIN_GO, S_FIN_WAIT
  } srch_state_t;
endpackage

// File: rtl/pll_rdiv.sv
module pll_rdiv #(
  parameter int NW = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [NW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          done_o,
  output logic [NW-1:0] quo_o
);
  localparam int CW = $clog2(NW + 1);
  localparam int RW = NW + DW;

  logic          busy_q, busy_n, done_q, done_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [NW-1:0] quo_q, quo_n, dvd_q, dvd_n;
  logic [DW-1:0] rem_q, rem_n, dvs_q, dvs_n;
  logic [DW:0]   shifted, diff;

  assign shifted = {rem_q, quo_q[NW-1]};
  assign diff    = shifted - {1'b0, dvs_q};

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    cnt_n  = cnt_q;
    quo_n  = quo_q;
    rem_n  = rem_q;
    dvs_n  = dvs_q;
    dvd_n  = dvd_q;
    if (start_i && !busy_q) begin
      busy_n = 1'b1;
      cnt_n  = CW'(NW);
      quo_n  = dividend_i;
      dvd_n  = dividend_i;
      rem_n  = '0;
      dvs_n  = divisor_i;
    end else if (busy_q) begin
      if (shifted >= {1'b0, dvs_q}) begin
        rem_n = diff[DW-1:0];
        quo_n = {quo_q[NW-2:0], 1'b1};
      end else begin
        rem_n = shifted[DW-1:0];
        quo_n = {quo_q[NW-2:0], 1'b0};
      end
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
      quo_q  <= quo_n;
      rem_q  <= rem_n;
      dvs_q  <= dvs_n;
      dvd_q  <= dvd_n;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R11
  div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (RW'(quo_q) * RW'(dvs_q) + RW'(rem_q)) == RW'(dvd_q));
  // R11
  div_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && !done_q));
endmodule

// File: rtl/pll_odiv_sel.sv
module pll_odiv_sel #(
  parameter int FW   = 32,
  parameter int F25  = 25_000_000,
  parameter int F50  = 50_000_000,
  parameter int F100 = 100_000_000,
  parameter int F200 = 200_000_000
) (
  input  logic [FW-1:0] req_i,
  output logic          ok_o,
  output logic [1:0]    code_o,
  output logic [FW-1:0] tgt_o
);
  always_comb begin
    ok_o = (req_i >= FW'(F25)) && (req_i <= FW'(F200));
    if (req_i > FW'(F100)) begin
      code_o = 2'd0;
      tgt_o  = req_i;
    end else if (req_i >= FW'(F50)) begin
      code_o = 2'd1;
      tgt_o  = {req_i[FW-2:0], 1'b0};
    end else begin
      code_o = 2'd3;
      tgt_o  = {req_i[FW-3:0], 2'b00};
    end
  end
endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
  import pll_srch_pkg::*;
#(
  parameter int FW       = 32,
  parameter int NR_MAX   = 33,
  parameter int NF_MAX   = 513,
  parameter int NR_ST_XT = 2,
  parameter int NR_ST_RC = 4,
  parameter int REF_LO   = 1_600_000,
  parameter int REF_HI   = 15_000_000,
  parameter int VCO_LO   = 100_000_000,
  parameter int VCO_HI   = 200_000_000,
  parameter int DEF_XT_CODE = 1,
  parameter int DEF_XT_NR   = 2,
  parameter int DEF_XT_NF   = 24,
  parameter int DEF_RC_CODE = 1,
  parameter int DEF_RC_NR   = 4,
  parameter int DEF_RC_NF   = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              src_i,
  input  logic [FW-1:0]     ref_hz_i,
  input  logic [FW-1:0]     req_hz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fallback_o,
  output logic [WORD_W-1:0] ctrl_word_o,
  output logic [FW-1:0]     freq_hz_o
);
  localparam int NRW = $clog2(NR_MAX + 2);
  localparam int NFW = $clog2(NF_MAX + 2);
  localparam int PW  = FW + NFW;
  localparam int DVW = $clog2(4 * NR_MAX + 1);

  srch_state_t     state_q, state_n;
  logic            src_q, src_n, pass_q, pass_n, fbw_q, fbw_n, fbo_q, fbo_n;
  logic            done_q, done_n, load_def;
  logic [1:0]      code_q, code_n;
  logic [FW-1:0]   tgt_q, tgt_n, ref_q, ref_n, freq_q, freq_n;
  logic [NRW-1:0]  nr_q, nr_n, nrs_q, nrs_n;
  logic [NFW-1:0]  nf_q, nf_n, nfs_q, nfs_n;
  logic [PW-1:0]   best_q, best_n, prod, err;
  logic [WORD_W-1:0] word_q, word_n, pack_w;

  logic            sel_ok;
  logic [1:0]      sel_code;
  logic [FW-1:0]   sel_tgt;
  logic            div_start, div_done;
  logic [DVW-1:0]  div_dvs;
  logic [FW-1:0]   div_quo;
  logic            q_ok, vco_ok, vco_over;

  pll_odiv_sel #(.FW(FW)) u_sel (
    .req_i(req_hz_i), .ok_o(sel_ok), .code_o(sel_code), .tgt_o(sel_tgt)
  );

  assign div_start = ((state_q == S_NR_CHK) && (nr_q <= NRW'(NR_MAX))) ||
                     (state_q == S_FIN_GO);
  assign div_dvs   = (state_q == S_FIN_GO) ?
                     DVW'((DVW'(code_q) + DVW'(1)) * DVW'(nrs_q)) : DVW'(nr_q);

  pll_rdiv #(.NW(FW), .DW(DVW)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(div_start), .dividend_i(ref_q),
    .divisor_i(div_dvs), .done_o(div_done), .quo_o(div_quo)
  );

  assign prod     = PW'(div_quo) * PW'(nf_q);
  assign err      = (prod > PW'(tgt_q)) ? (prod - PW'(tgt_q)) : (PW'(tgt_q) - prod);
  assign q_ok     = (div_quo > FW'(REF_LO)) && (div_quo < FW'(REF_HI));
  assign vco_over = prod > PW'(VCO_HI);
  assign vco_ok   = prod >= PW'(VCO_LO);

  always_comb begin
    pack_w = '0;
    pack_w[SRC_BIT] = src_q;
    pack_w[CODE_LSB +: 2] = code_q;
    pack_w[NRF_LSB +: NRF_W] = NRF_W'(nrs_q - NRW'(2));
    pack_w[0 +: NFF_W] = NFF_W'(nfs_q - NFW'(2));
  end

  always_comb begin
    state_n = state_q;  src_n = src_q;   ref_n = ref_q;   code_n = code_q;
    tgt_n   = tgt_q;    nr_n  = nr_q;    nf_n  = nf_q;    best_n = best_q;
    pass_n  = pass_q;   nrs_n = nrs_q;   nfs_n = nfs_q;   fbw_n  = fbw_q;
    word_n  = word_q;   freq_n = freq_q; fbo_n = fbo_q;   done_n = 1'b0;
    load_def = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        src_n = src_i;
        ref_n = ref_hz_i;
        if (sel_ok) begin
          code_n  = sel_code;
          tgt_n   = sel_tgt;
          nr_n    = src_i ? NRW'(NR_ST_RC) : NRW'(NR_ST_XT);
          pass_n  = 1'b0;
          best_n  = '1;
          state_n = S_NR_CHK;
        end else begin
          load_def = 1'b1;
        end
      end
      S_NR_CHK: begin
        if (nr_q > NRW'(NR_MAX)) begin
          if (!pass_q && (best_q != '1)) begin
            pass_n = 1'b1;
            nr_n   = src_q ? NRW'(NR_ST_RC) : NRW'(NR_ST_XT);
          end else begin
            load_def = 1'b1;
          end
        end else begin
          state_n = S_NR_WAIT;
        end
      end
      S_NR_WAIT: if (div_done) begin
        if (q_ok) begin
          nf_n    = NFW'(2);
          state_n = S_SCAN;
        end else begin
          nr_n    = nr_q + NRW'(1);
          state_n = S_NR_CHK;
        end
      end
      S_SCAN: begin
        if ((nf_q > NFW'(NF_MAX)) || vco_over) begin
          nr_n    = nr_q + NRW'(1);
          state_n = S_NR_CHK;
        end else begin
          nf_n = nf_q + NFW'(1);
          if (vco_ok) begin
            if (!pass_q) begin
              if (err < best_q) begin
                best_n = err;
                if (err == '0) begin
                  nrs_n = nr_q; nfs_n = nf_q; fbw_n = 1'b0; state_n = S_FIN_GO;
                end
              end
            end else if (err == best_q) begin
              nrs_n = nr_q; nfs_n = nf_q; fbw_n = 1'b0; state_n = S_FIN_GO;
            end
          end
        end
      end
      S_FIN_GO: state_n = S_FIN_WAIT;
      S_FIN_WAIT: if (div_done) begin
        freq_n  = FW'(PW'(div_quo) * PW'(nfs_q));
        word_n  = pack_w;
        fbo_n   = fbw_q;
        done_n  = 1'b1;
        state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
    if (load_def) begin
      code_n  = src_n ? 2'(DEF_RC_CODE) : 2'(DEF_XT_CODE);
      nrs_n   = src_n ? NRW'(DEF_RC_NR) : NRW'(DEF_XT_NR);
      nfs_n   = src_n ? NFW'(DEF_RC_NF) : NFW'(DEF_XT_NF);
      fbw_n   = 1'b1;
      state_n = S_FIN_GO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; src_q <= 1'b0; ref_q <= '0; code_q <= '0;
      tgt_q   <= '0;     nr_q  <= '0;   nf_q  <= '0; best_q <= '0;
      pass_q  <= 1'b0;   nrs_q <= '0;   nfs_q <= '0; fbw_q  <= 1'b0;
      word_q  <= '0;     freq_q <= '0;  fbo_q <= 1'b0; done_q <= 1'b0;
    end else begin
      state_q <= state_n; src_q <= src_n; ref_q <= ref_n; code_q <= code_n;
      tgt_q   <= tgt_n;   nr_q  <= nr_n;  nf_q  <= nf_n;  best_q <= best_n;
      pass_q  <= pass_n;  nrs_q <= nrs_n; nfs_q <= nfs_n; fbw_q  <= fbw_n;
      word_q  <= word_n;  freq_q <= freq_n; fbo_q <= fbo_n; done_q <= done_n;
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign fallback_o  = fbo_q;
  assign ctrl_word_o = word_q;
  assign freq_hz_o   = freq_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && start_i) |=> ($stable(ref_q) && $stable(src_q) && $stable(tgt_q)));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == S_IDLE));
  // R1
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !fbo_q) |-> (word_q[CODE_LSB +: 2] != 2'd2));
  // R5
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SCAN && !pass_q && $past(state_q) == S_SCAN) |-> (best_q <= $past(best_q)));
endmodule

// File: tb/tb_pll_param_search.sv
module tb_pll_param_search;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 30000;
  localparam int WD  = 190000;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, src = 1'b0;
  logic [31:0] ref_hz = '0, req_hz = '0;
  logic        busy, done, fb;
  logic [19:0] word;
  logic [31:0] freq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_param_search dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .src_i(src),
    .ref_hz_i(ref_hz), .req_hz_i(req_hz), .busy_o(busy), .done_o(done),
    .fallback_o(fb), .ctrl_word_o(word), .freq_hz_o(freq)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", rq, what, act, act, exp, exp);
    end
  endtask

  // Independent exhaustive model of R1..R8
  task automatic model(input logic [31:0] rf, input bit s, input logic [31:0] rq,
                       output logic [19:0] w, output logic [31:0] f, output bit fbk);
    longint tgt, best, q, p, e;
    int code, bnr, bnf, nr, nf;
    bit found = 0;
    best = -1;
    bnr = 0; bnf = 0; code = 0; tgt = 0;
    if (rq > 100_000_000) begin code = 0; tgt = rq; end
    else if (rq >= 50_000_000) begin code = 1; tgt = longint'(rq) * 2; end
    else begin code = 3; tgt = longint'(rq) * 4; end
    if (rq >= 25_000_000 && rq <= 200_000_000) begin
      for (int r = (s ? 4 : 2); r <= 33; r++) begin
        q = rf / r;
        if (q > 1_600_000 && q < 15_000_000) begin
          for (int n = 2; n <= 513; n++) begin
            p = q * n;
            if (p >= 100_000_000 && p <= 200_000_000) begin
              e = (p > tgt) ? p - tgt : tgt - p;
              if (!found || e < best) begin best = e; bnr = r; bnf = n; found = 1; end
            end
          end
        end
      end
    end
    if (found) begin nr = bnr; nf = bnf; fbk = 0; end
    else begin code = 1; nr = s ? 4 : 2; nf = s ? 26 : 24; fbk = 1; end
    w = '0;
    w[19] = s;
    w[15:14] = code[1:0];
    w[13:9] = 5'(nr - 2);
    w[8:0] = 9'(nf - 2);
    f = 32'((longint'(rf) / ((code + 1) * nr)) * nf);
  endtask

  task automatic run_case(input string tag, input logic [31:0] rf, input bit s,
                          input logic [31:0] rq, input bit poke);
    logic [19:0] ew; logic [31:0] ef; bit efb; int n;
    model(rf, s, rq, ew, ef, efb);
    @(negedge clk); ref_hz = rf; src = s; req_hz = rq; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    if (poke) begin
      // R9: second start while busy must be ignored
      repeat (3) @(negedge clk);
      ref_hz = 32'd22_118_400; src = ~s; req_hz = 32'd33_000_000; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < TMO) begin @(negedge clk); n++; end
    chk(done == 1'b1, tag, "done seen", done, 1);
    chk(word == ew, tag, "control word", word, ew);
    chk(freq == ef, "R7", "frequency", freq, ef);
    chk(fb == efb, tag, "fallback", fb, efb);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10", "done one cycle", {done, busy}, 0);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && fb == 0 && word == 0 && freq == 0,
        "R10", "reset state", {busy, done, fb, word, freq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case("R5", 32'd12_000_000, 1'b0, 32'd72_000_000, 1'b0);   // exact, R6 layout
    run_case("R1", 32'd12_000_000, 1'b0, 32'd200_000_000, 1'b0);
    run_case("R1", 32'd12_000_000, 1'b0, 32'd100_000_000, 1'b0);
    run_case("R1", 32'd12_000_000, 1'b0, 32'd100_000_001, 1'b0);
    run_case("R1", 32'd12_000_000, 1'b0, 32'd50_000_000, 1'b0);
    run_case("R1", 32'd12_000_000, 1'b0, 32'd49_999_999, 1'b0);
    run_case("R1", 32'd12_000_000, 1'b0, 32'd25_000_000, 1'b0);
    run_case("R2", 32'd12_000_000, 1'b0, 32'd24_999_999, 1'b0);
    run_case("R2", 32'd22_118_400, 1'b1, 32'd200_000_001, 1'b0);
    run_case("R3", 32'd22_118_400, 1'b1, 32'd147_456_000, 1'b0);   // NR=3 would be exact
    run_case("R8", 32'd1_000_000, 1'b0, 32'd60_000_000, 1'b0);     // R4 window never met
    run_case("R11", 32'd13_000_001, 1'b0, 32'd77_777_777, 1'b0);   // truncating divisions
    run_case("R9", 32'd12_000_000, 1'b0, 32'd72_000_000, 1'b1);
    for (int i = 0; i < 8; i++) begin
      bit s = 1'($urandom % 2);
      logic [31:0] rf = s ? 32'd22_118_400 : 32'd4_000_000 + ($urandom % 21_000_000);
      logic [31:0] rq = 32'd20_000_000 + ($urandom % 190_000_000);
      run_case("R4", rf, s, rq, 1'b0);   // R5 minimum over random requests
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule